// File: doc/BRIEF.md
# TFT Panel Timing Generator

This block drives the control side of an active-matrix TFT panel. From the bus clock it derives a pixel clock and a one-cycle pixel clock enable. It walks a horizontal counter through sync, back porch, active and front porch regions, and steps a vertical counter through the same regions once per line. From these counters it produces horizontal sync, vertical sync and data enable. Each of these outputs, and the pixel clock, has its own polarity inversion.

A downstream fetch unit receives the position of the current active pixel, the current active line, and a start-of-frame strobe. It supplies pixel words over a valid/ready stream. Ready is asserted for one bus cycle per active pixel, on the pixel clock enable. The timing never stalls. If valid is low when ready is asserted, that pixel is shown black and the word is not consumed. A stored mode code unpacks each word into 8-bit red, green and blue.

All timing fields hold the desired count minus one. While the enable is low, the configuration is copied every cycle. While the enable is high, a new configuration is taken only at the start of the next frame.

Top module: `tft_timing_gen`

## Requirements
- R1: With enable high, `pix_ce` is high for one bus cycle in every 2*(cfg_div+1) bus cycles, in the last cycle of each pixel period. The raw pixel clock is low for the first cfg_div+1 cycles of the period and high for the rest, so data changes before its rising edge.
- R2: Each line lasts hsw+hbp+hact+hfp+4 pixel periods. It runs sync (hsw+1), back porch (hbp+1), active (hact+1) and front porch (hfp+1), in that order. `pix_x` is the index within the active region and is 0 outside it.
- R3: Each frame runs the same four regions in lines, using vsw, vbp, vact and vfp. `line_y` is the active line index and is 0 outside the active region.
- R4: Data enable is active only while both the horizontal and the vertical position are inside their active regions.
- R5: With an inversion bit clear, hsync, vsync and data enable are active high and the pixel clock is the raw clock. With a bit set, that one output is inverted.
- R6: Mode 12 maps word bits 15:11, 10:5 and 4:0 to red, green and blue, widened to 8 bits by repeating their top bits. Mode 13 maps bits 23:16, 15:8 and 7:0. Any other mode gives zero colour. Colour is zero whenever data enable is inactive.
- R7: `pix_ready` is high exactly when `pix_ce` is high and data enable is active. If `pix_valid` is low in an active pixel, the colour is zero and the timing is unchanged.
- R8: `sof` is high for one bus cycle: the first cycle after enable rises, and the first bus cycle of pixel (0,0) in every later frame.
- R9: With enable low, syncs and data enable sit at their inactive levels, the pixel clock sits at its inverted-or-not low level, and `pix_ce`, `pix_ready`, `sof` and colour are 0.
- R10: Configuration changed while enabled leaves the current frame untouched and applies from the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Video output enable |
| cfg_div | input | 10 | Pixel clock divider |
| cfg_hsw | input | 8 | Horizontal sync width minus one |
| cfg_hbp | input | 7 | Horizontal back porch minus one |
| cfg_hact | input | 11 | Active pixels minus one |
| cfg_hfp | input | 8 | Horizontal front porch minus one |
| cfg_vsw | input | 6 | Vertical sync width minus one |
| cfg_vbp | input | 8 | Vertical back porch minus one |
| cfg_vact | input | 10 | Active lines minus one |
| cfg_vfp | input | 8 | Vertical front porch minus one |
| cfg_inv_hs | input | 1 | Invert hsync |
| cfg_inv_vs | input | 1 | Invert vsync |
| cfg_inv_de | input | 1 | Invert data enable |
| cfg_inv_pclk | input | 1 | Invert pixel clock |
| cfg_mode | input | 4 | Pixel format code |
| pix_valid | input | 1 | Pixel word valid |
| pix_ready | output | 1 | Pixel word consumed this cycle |
| pix_data | input | 24 | Pixel word |
| pclk | output | 1 | Pixel clock to panel |
| pix_ce | output | 1 | Pixel clock enable, bus domain |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| red | output | 8 | Red component |
| green | output | 8 | Green component |
| blue | output | 8 | Blue component |
| pix_x | output | 11 | Active pixel index |
| line_y | output | 10 | Active line index |
| sof | output | 1 | Start-of-frame strobe |

## Verification
The assertions check on every cycle that the block is silent while disabled, and that ready only appears on a pixel clock enable. They also check that the enable never fires on two consecutive cycles, that active video never overlaps horizontal sync, that colour is zero outside active video, and that a start-of-frame strobe follows each rise of the enable. The exact region lengths, the divider period, the polarity of each output, the two colour unpackings and the deferral of a mid-frame configuration change depend on the programmed values. Only the bench scenarios can show these, because they compare every output against positions computed from the pixel count.

// File: rtl/tft_timing_pkg.sv
package tft_timing_pkg;
  localparam int DIV_W  = 10;
  localparam int HSW_W  = 8;
  localparam int HBP_W  = 7;
  localparam int HACT_W = 11;
  localparam int HFP_W  = 8;
  localparam int VSW_W  = 6;
  localparam int VBP_W  = 8;
  localparam int VACT_W = 10;
  localparam int VFP_W  = 8;
  localparam int MODE_W = 4;
  localparam int COMP_W = 8;
  localparam int PIX_W  = 3 * COMP_W;
  localparam int H_CNT_W = HACT_W + 2;
  localparam int V_CNT_W = VACT_W + 2;

  localparam logic [MODE_W-1:0] MODE_RGB565 = MODE_W'(12);
  localparam logic [MODE_W-1:0] MODE_RGB888 = MODE_W'(13);

  typedef struct packed {
    logic [DIV_W-1:0]  div;
    logic [HSW_W-1:0]  hsw;
    logic [HBP_W-1:0]  hbp;
    logic [HACT_W-1:0] hact;
    logic [HFP_W-1:0]  hfp;
    logic [VSW_W-1:0]  vsw;
    logic [VBP_W-1:0]  vbp;
    logic [VACT_W-1:0] vact;
    logic [VFP_W-1:0]  vfp;
    logic              inv_hs;
    logic              inv_vs;
    logic              inv_de;
    logic              inv_pclk;
    logic [MODE_W-1:0] mode;
  } tft_cfg_t;

  typedef struct packed {
    logic [COMP_W-1:0] r;
    logic [COMP_W-1:0] g;
    logic [COMP_W-1:0] b;
  } tft_rgb_t;

  function automatic tft_rgb_t unpack_word(input logic [MODE_W-1:0] mode,
                                           input logic [PIX_W-1:0] w);
    tft_rgb_t o;
    o = '0;
    if (mode == MODE_RGB565) begin
      o.r = {w[15:11], w[15:13]};
      o.g = {w[10:5],  w[10:9]};
      o.b = {w[4:0],   w[4:2]};
    end else if (mode == MODE_RGB888) begin
      o.r = w[23:16];
      o.g = w[15:8];
      o.b = w[7:0];
    end
    return o;
  endfunction
endpackage

// File: rtl/tft_pclk_div.sv
module tft_pclk_div #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          ce,
  output logic          phase
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (!en) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (cnt == div) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // one enable per full period: second half, last bus cycle
  assign ce = en && phase && (cnt == div);
endmodule

// File: rtl/tft_axis_seq.sv
module tft_axis_seq #(
  parameter int SW_W  = 8,
  parameter int BP_W  = 7,
  parameter int ACT_W = 11,
  parameter int FP_W  = 8,
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic [SW_W-1:0]  sw_m1,
  input  logic [BP_W-1:0]  bp_m1,
  input  logic [ACT_W-1:0] act_m1,
  input  logic [FP_W-1:0]  fp_m1,
  output logic             in_sync,
  output logic             in_act,
  output logic             wrap,
  output logic [ACT_W-1:0] idx
);
  logic [CNT_W-1:0] cnt, act_start, act_end, last;

  always_comb begin
    act_start = CNT_W'(sw_m1) + CNT_W'(bp_m1) + CNT_W'(2);
    act_end   = act_start + CNT_W'(act_m1) + CNT_W'(1);
    last      = act_end + CNT_W'(fp_m1);
  end

  assign in_sync = (cnt <= CNT_W'(sw_m1));
  assign in_act  = (cnt >= act_start) && (cnt < act_end);
  assign idx     = in_act ? ACT_W'(cnt - act_start) : '0;
  assign wrap    = step && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tft_timing_gen.sv
module tft_timing_gen
  import tft_timing_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [HSW_W-1:0]  cfg_hsw,
  input  logic [HBP_W-1:0]  cfg_hbp,
  input  logic [HACT_W-1:0] cfg_hact,
  input  logic [HFP_W-1:0]  cfg_hfp,
  input  logic [VSW_W-1:0]  cfg_vsw,
  input  logic [VBP_W-1:0]  cfg_vbp,
  input  logic [VACT_W-1:0] cfg_vact,
  input  logic [VFP_W-1:0]  cfg_vfp,
  input  logic              cfg_inv_hs,
  input  logic              cfg_inv_vs,
  input  logic              cfg_inv_de,
  input  logic              cfg_inv_pclk,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pclk,
  output logic              pix_ce,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [COMP_W-1:0] red,
  output logic [COMP_W-1:0] green,
  output logic [COMP_W-1:0] blue,
  output logic [HACT_W-1:0] pix_x,
  output logic [VACT_W-1:0] line_y,
  output logic              sof
);
  tft_cfg_t cfg_live, shad;
  logic     ce, phase;
  logic     h_sync, h_act, h_wrap;
  logic     v_sync, v_act, v_wrap;
  logic     hs_act, vs_act, de_act;
  logic     run, sof_q;
  tft_rgb_t px;

  assign cfg_live = '{div: cfg_div, hsw: cfg_hsw, hbp: cfg_hbp, hact: cfg_hact,
                      hfp: cfg_hfp, vsw: cfg_vsw, vbp: cfg_vbp, vact: cfg_vact,
                      vfp: cfg_vfp, inv_hs: cfg_inv_hs, inv_vs: cfg_inv_vs,
                      inv_de: cfg_inv_de, inv_pclk: cfg_inv_pclk, mode: cfg_mode};

  // working copy: follows the inputs while idle, reloads at frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                shad <= '0;
    else if (!en || v_wrap)    shad <= cfg_live;
  end

  tft_pclk_div #(.DW(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(en), .div(shad.div), .ce(ce), .phase(phase)
  );

  tft_axis_seq #(.SW_W(HSW_W), .BP_W(HBP_W), .ACT_W(HACT_W), .FP_W(HFP_W),
                 .CNT_W(H_CNT_W)) u_hseq (
    .clk(clk), .rst_n(rst_n), .clr(!en), .step(ce),
    .sw_m1(shad.hsw), .bp_m1(shad.hbp), .act_m1(shad.hact), .fp_m1(shad.hfp),
    .in_sync(h_sync), .in_act(h_act), .wrap(h_wrap), .idx(pix_x)
  );

  tft_axis_seq #(.SW_W(VSW_W), .BP_W(VBP_W), .ACT_W(VACT_W), .FP_W(VFP_W),
                 .CNT_W(V_CNT_W)) u_vseq (
    .clk(clk), .rst_n(rst_n), .clr(!en), .step(h_wrap),
    .sw_m1(shad.vsw), .bp_m1(shad.vbp), .act_m1(shad.vact), .fp_m1(shad.vfp),
    .in_sync(v_sync), .in_act(v_act), .wrap(v_wrap), .idx(line_y)
  );

  assign hs_act = en && h_sync;
  assign vs_act = en && v_sync;
  assign de_act = en && h_act && v_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      run   <= en;
      sof_q <= v_wrap;
    end
  end

  assign sof = en && (!run || sof_q);

  assign pix_ce    = ce;
  assign pclk      = phase ^ shad.inv_pclk;
  assign hsync     = hs_act ^ shad.inv_hs;
  assign vsync     = vs_act ^ shad.inv_vs;
  assign de        = de_act ^ shad.inv_de;
  assign pix_ready = de_act && ce;

  assign px    = unpack_word(shad.mode, pix_data);
  assign red   = (de_act && pix_valid) ? px.r : '0;
  assign green = (de_act && pix_valid) ? px.g : '0;
  assign blue  = (de_act && pix_valid) ? px.b : '0;
endmodule

// File: rtl/tft_timing_gen_chk.sv
module tft_timing_gen_chk
  import tft_timing_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              pix_ce,
  input logic              pix_ready,
  input logic              sof,
  input logic              hs_act,
  input logic              de_act,
  input logic [COMP_W-1:0] red,
  input logic [COMP_W-1:0] green,
  input logic [COMP_W-1:0] blue
);
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!pix_ce && !pix_ready && !sof && !hs_act && !de_act));

  assert_ready_on_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> pix_ce);

  assert_ce_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ce |=> !pix_ce);

  assert_de_outside_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    de_act |-> !hs_act);

  assert_sof_on_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en)) |-> sof);

  assert_blank_colour_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !de_act |-> (red == '0 && green == '0 && blue == '0));
endmodule

bind tft_timing_gen tft_timing_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pix_ce(pix_ce), .pix_ready(pix_ready),
  .sof(sof), .hs_act(hs_act), .de_act(de_act),
  .red(red), .green(green), .blue(blue)
);

// File: tb/tft_timing_gen_test.sv
module tft_timing_gen_test;
  import tft_timing_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  always #10 clk = ~clk;

  tft_cfg_t live, cur;
  logic pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic pix_ready, pclk, pix_ce, hsync, vsync, de, sof;
  logic [COMP_W-1:0] red, green, blue;
  logic [HACT_W-1:0] pix_x;
  logic [VACT_W-1:0] line_y;

  int errors = 0, checks = 0;
  int c, k;
  bit done = 0;

  tft_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_div(live.div), .cfg_hsw(live.hsw), .cfg_hbp(live.hbp), .cfg_hact(live.hact),
    .cfg_hfp(live.hfp), .cfg_vsw(live.vsw), .cfg_vbp(live.vbp), .cfg_vact(live.vact),
    .cfg_vfp(live.vfp), .cfg_inv_hs(live.inv_hs), .cfg_inv_vs(live.inv_vs),
    .cfg_inv_de(live.inv_de), .cfg_inv_pclk(live.inv_pclk), .cfg_mode(live.mode),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .pclk(pclk), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync), .de(de),
    .red(red), .green(green), .blue(blue), .pix_x(pix_x), .line_y(line_y), .sof(sof)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic int period();  return 2 * (int'(cur.div) + 1); endfunction
  function automatic int htot();
    return int'(cur.hsw) + int'(cur.hbp) + int'(cur.hact) + int'(cur.hfp) + 4;
  endfunction
  function automatic int vtot();
    return int'(cur.vsw) + int'(cur.vbp) + int'(cur.vact) + int'(cur.vfp) + 4;
  endfunction

  function automatic logic [23:0] exp_rgb(input logic [3:0] m, input logic [23:0] w);
    logic [4:0] r5, b5; logic [5:0] g6;
    if (m == 4'd13) return w;
    if (m == 4'd12) begin
      r5 = w[15:11]; g6 = w[10:5]; b5 = w[4:0];
      return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
    end
    return 24'h0;
  endfunction

  task automatic check_cycle(input string tag);
    int p = period();
    int ht = htot();
    int h = k % ht;
    int v = k / ht;
    int hs_e = int'(cur.hsw) + 1;
    int ha_s = int'(cur.hsw) + int'(cur.hbp) + 2;
    int ha_e = ha_s + int'(cur.hact) + 1;
    int vs_e = int'(cur.vsw) + 1;
    int va_s = int'(cur.vsw) + int'(cur.vbp) + 2;
    int va_e = va_s + int'(cur.vact) + 1;
    bit hin = (h >= ha_s) && (h < ha_e);
    bit vin = (v >= va_s) && (v < va_e);
    bit dea = hin && vin;
    bit ce = (c == p - 1);
    chk({tag, "R1 pix_ce"}, pix_ce, ce);
    chk({tag, "R1 R5 pclk"}, pclk, (c >= int'(cur.div) + 1) ^ cur.inv_pclk);
    chk({tag, "R2 R5 hsync"}, hsync, (h < hs_e) ^ cur.inv_hs);
    chk({tag, "R2 pix_x"}, pix_x, hin ? h - ha_s : 0);
    chk({tag, "R3 R5 vsync"}, vsync, (v < vs_e) ^ cur.inv_vs);
    chk({tag, "R3 line_y"}, line_y, vin ? v - va_s : 0);
    chk({tag, "R4 R5 de"}, de, dea ^ cur.inv_de);
    chk({tag, "R7 pix_ready"}, pix_ready, dea && ce);
    chk({tag, "R8 sof"}, sof, (c == 0) && (k == 0));
    chk({tag, "R6 R7 rgb"}, {red, green, blue},
        (dea && pix_valid) ? exp_rgb(cur.mode, pix_data) : 24'h0);
  endtask

  task automatic advance();
    int p = period();
    int ft = htot() * vtot();
    c++;
    if (c == p) begin
      c = 0;
      k++;
      if (k == ft) begin
        k = 0;
        cur = live;   // R10: new settings only from the frame boundary
      end
    end
  endtask

  task automatic check_idle(input tft_cfg_t cfg);
    @(negedge clk);
    en = 1'b0;
    live = cfg;
    @(negedge clk);
    @(negedge clk);
    pix_valid = 1'b1;
    pix_data = 24'hFFFFFF;
    #2;
    chk("R9 hsync", hsync, cfg.inv_hs);
    chk("R9 vsync", vsync, cfg.inv_vs);
    chk("R9 de", de, cfg.inv_de);
    chk("R9 pclk", pclk, cfg.inv_pclk);
    chk("R9 strobes", {pix_ce, pix_ready, sof}, 3'b000);
    chk("R9 rgb", {red, green, blue}, 24'h0);
  endtask

  task automatic run(input int ncyc, input int chg_at, input tft_cfg_t nxt, input string tag);
    cur = live;
    c = 0;
    k = 0;
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      if (i == 0) en = 1'b1;
      if (i == chg_at) live = nxt;
      pix_data = 24'(i * 40503 + 12345) ^ 24'(i << 13);
      pix_valid = (i % 7) != 3;
      #2;
      check_cycle(tag);
      advance();
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  function automatic tft_cfg_t make_cfg(input int set, input int dv, input logic [3:0] m,
                                        input int inv);
    tft_cfg_t t;
    t = '0;
    t.div = DIV_W'(dv);
    t.mode = m;
    {t.inv_hs, t.inv_vs, t.inv_de, t.inv_pclk} = 4'(inv);
    if (set == 0) begin
      t.hsw = 0; t.hbp = 1; t.hact = 3; t.hfp = 0;
      t.vsw = 0; t.vbp = 0; t.vact = 2; t.vfp = 1;
    end else begin
      t.hsw = 1; t.hbp = 0; t.hact = 1; t.hfp = 2;
      t.vsw = 1; t.vbp = 1; t.vact = 1; t.vfp = 0;
    end
    return t;
  endfunction

  initial begin
    logic [3:0] modes [3] = '{4'd12, 4'd13, 4'd5};
    live = make_cfg(0, 0, 4'd12, 0);
    repeat (3) @(negedge clk);
    // reset state
    chk("R9 reset hsync", hsync, 1'b0);
    chk("R9 reset strobes", {pix_ce, pix_ready, sof, de}, 4'b0000);
    rst_n = 1'b1;
    for (int dv = 0; dv < 3; dv++)
      for (int s = 0; s < 2; s++)
        for (int mi = 0; mi < 3; mi++) begin
          tft_cfg_t t = make_cfg(s, dv, modes[mi], (dv * 6 + s * 3 + mi * 5) % 16);
          check_idle(t);
          run(2 * 56 * 2 * (dv + 1) + 5, -1, t, "");
        end
    // R10: mid-frame change of timing, divider and polarity
    check_idle(make_cfg(0, 0, 4'd13, 0));
    run(56 * 2 + 56 * 4 * 2 + 9, 30, make_cfg(1, 1, 4'd12, 15), "R10 ");
    check_idle(make_cfg(1, 2, 4'd13, 9));
    run(56 * 6 * 2 + 20, 100, make_cfg(0, 0, 4'd13, 6), "R10 ");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule